// File: doc/BRIEF.md
# SPI Controller Register Block

This block is the memory-mapped register front end of a serial peripheral controller. A processor bus reaches it with a read strobe, a write strobe, an offset within the block's window, a transfer-size code and 16-bit write data. The block returns registered read data and an error flag. It holds seven 16-bit registers, and it drives the current status word on a dedicated output.

Most of the registers are plain storage. The status flags are different: they move as a side effect of bus traffic. A write to the transmit buffer can raise the receive-ready flag and drop the transmit-ready flag. A read of the receive buffer can drop both. Which of these takes effect depends on the enable bit and the transfer-initiate mode held in the control register. Software writes to status clear bits by writing ones, but three hardware-owned flags are immune.

Each access starts on the cycle in which a strobe rises. Its side effects happen exactly once, however long the strobe is held. The read data and error response appear in the following cycle and stay until the next access starts.

Top module: `spi_regblk`

## Requirements
- R1: After reset, control reads 0x0400, chip-select flags read 0xFF00, status reads 0x0001, all other registers read 0x0000, `status_o` is 0x0001, and `bus_rdata` and `bus_err` are 0.
- R2: With a 16-bit access, the registers decode at these offsets: control 0x00, chip-select flags 0x04, status 0x08, transmit buffer 0x0C, receive buffer 0x10, baud divisor 0x14, shadow 0x18. Control, flags, transmit buffer, receive buffer, baud and shadow read back the last value written.
- R3: `bus_size` encodes 00 = byte, 01 = 16-bit, 10 = 32-bit, 11 = reserved. Every access whose size is not 01 gets `bus_err` = 1 at any offset. The size check is made before the offset check.
- R4: A legal-size access to an offset whose low two bits are not 00, or at or above 0x1C, gets `bus_err` = 1.
- R5: An access that errors changes no register and returns `bus_rdata` = 0. Any write returns `bus_rdata` = 0.
- R6: A write to status clears each bit written as 1, except bit 0 (shift-done flag), bit 3 (transmit-ready flag) and bit 5 (receive-ready flag), which software writes never change. A status write never sets a bit.
- R7: A transmit-buffer write stores the data. When control bit 14 (enable) is 1 and control bits 1:0 are 01 (transmit-initiated), the same write sets status bit 5 and clears status bit 3. Otherwise status is unchanged.
- R8: A receive-buffer read returns its contents. When control bit 14 is 1 and control bits 1:0 are 00 (receive-initiated), the read clears status bits 5 and 3. Otherwise status is unchanged.
- R9: An access begins on the cycle in which `bus_rd | bus_wr` rises. Holding the strobe for more cycles, even with a changed offset or data, causes no further effect. The response is valid one cycle after the start and holds until the next access starts.
- R10: `status_o` equals the status register, changes in the cycle after the access that changed it, and matches what a status read returns.
- R11: An access with both strobes high is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over read) |
| bus_addr | input | ADDR_W | Byte offset within the block window |
| bus_size | input | 2 | Access size code (01 = 16-bit) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered error response |
| status_o | output | 16 | Current status word |

## Verification
The bench builds the block with ADDR_W = 5, so the whole 32-byte window is swept at every offset with all four size codes, for both reads and writes. This sweep covers every error case and shows that erroring writes leave all seven registers intact. The two enable settings and all four mode codes are crossed with transmit-buffer writes and receive-buffer reads, and a bench model predicts each resulting status word. Held strobes with an offset that changes mid-access confirm that each access acts only once.

// File: rtl/spi_regblk_pkg.sv
package spi_regblk_pkg;

  localparam int DW       = 16;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    REG_CTL    = 3'd0,
    REG_FLG    = 3'd1,
    REG_STAT   = 3'd2,
    REG_TX     = 3'd3,
    REG_RX     = 3'd4,
    REG_BAUD   = 3'd5,
    REG_SHADOW = 3'd6
  } reg_sel_e;

  localparam logic [1:0] SIZE_HALF = 2'b01;
  localparam int SPIF_BIT = 0;
  localparam int TXS_BIT  = 3;
  localparam int RXS_BIT  = 5;
  localparam int EN_BIT   = 14;
  localparam logic [1:0] MODE_RX = 2'b00;
  localparam logic [1:0] MODE_TX = 2'b01;

  localparam logic [DW-1:0] HW_FLAGS = DW'((1 << SPIF_BIT) | (1 << TXS_BIT) | (1 << RXS_BIT));
  localparam logic [DW-1:0] RST_STAT = 16'h0001;

  function automatic logic [DW-1:0] reset_value(input int idx);
    case (idx)
      0:       return 16'h0400;
      1:       return 16'hFF00;
      2:       return RST_STAT;
      default: return '0;
    endcase
  endfunction

  // Software clear: ones clear bits, hardware-owned flags kept.
  function automatic logic [DW-1:0] stat_sw_clear(input logic [DW-1:0] cur, input logic [DW-1:0] wd);
    return cur & ~(wd & ~HW_FLAGS);
  endfunction

  function automatic logic [DW-1:0] stat_on_tx(input logic [DW-1:0] cur);
    logic [DW-1:0] v;
    v = cur;
    v[RXS_BIT] = 1'b1;
    v[TXS_BIT] = 1'b0;
    return v;
  endfunction

  function automatic logic [DW-1:0] stat_on_rx(input logic [DW-1:0] cur);
    logic [DW-1:0] v;
    v = cur;
    v[RXS_BIT] = 1'b0;
    v[TXS_BIT] = 1'b0;
    return v;
  endfunction

  function automatic logic mode_active(input logic [DW-1:0] ctl, input logic [1:0] mode);
    return ctl[EN_BIT] && (ctl[1:0] == mode);
  endfunction

endpackage

// File: rtl/spi_bus_front.sv
module spi_bus_front
  import spi_regblk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              acc_start,
  output logic              acc_write,
  output logic              acc_err,
  output reg_sel_e          acc_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic              strobe;
  logic              strobe_q;
  logic              size_ok;
  logic              map_ok;
  logic [IDX_W-1:0]  idx;

  assign strobe = rd | wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign acc_start = strobe & ~strobe_q;
  assign acc_write = wr;
  assign idx       = addr[ADDR_W-1:2];
  assign size_ok   = (size == SIZE_HALF);
  assign map_ok    = (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
  // Size is judged first; an unmapped offset only matters for a legal size.
  assign acc_err   = !size_ok ? 1'b1 : !map_ok;
  assign acc_sel   = reg_sel_e'(addr[4:2]);

  // R9: a start pulse lasts exactly one cycle
  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_start);

  // R3: a bad size always yields an error
  a_r3_size_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && size != SIZE_HALF) |-> acc_err);

endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
  import spi_regblk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_sw_write,
  input  logic          do_tx_set,
  input  logic          do_rx_clear,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stat_q <= RST_STAT;
    else if (do_sw_write) stat_q <= stat_sw_clear(stat_q, wdata);
    else if (do_tx_set)   stat_q <= stat_on_tx(stat_q);
    else if (do_rx_clear) stat_q <= stat_on_rx(stat_q);
  end

  // R6: software writes never set bits and never touch hardware flags
  a_r6_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    do_sw_write |=> ((stat_q & ~$past(stat_q)) == '0));
  a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    do_sw_write |=> ((stat_q & HW_FLAGS) == ($past(stat_q) & HW_FLAGS)));

  // R7: transmit-initiated write raises receive-ready, drops transmit-ready
  a_r7_tx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    do_tx_set |=> (stat_q[RXS_BIT] && !stat_q[TXS_BIT]));

  // R8: receive-initiated read drops both ready flags
  a_r8_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    do_rx_clear |=> (!stat_q[RXS_BIT] && !stat_q[TXS_BIT]));

  // R9: no event, no change
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_sw_write || do_tx_set || do_rx_clear) |=> $stable(stat_q));

endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
  import spi_regblk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_in,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] rd_mux
);
  logic [NUM_REGS-1:0][DW-1:0] file_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == int'(REG_STAT)) begin : g_stat
      assign file_q[i] = stat_in;
    end else begin : g_plain
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= reset_value(i);
        else if (wr_en && int'(sel) == i)     q <= wdata;
      end
      assign file_q[i] = q;
    end
  end

  assign ctl_q  = file_q[REG_CTL];
  assign rd_mux = file_q[sel];

endmodule

// File: rtl/spi_regblk.sv
module spi_regblk
  import spi_regblk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  output logic [DW-1:0]     status_o
);
  logic          acc_start, acc_write, acc_err;
  reg_sel_e      acc_sel;
  logic          acc_ok, wr_go, rd_go;
  logic          ev_sw_stat, ev_tx_set, ev_rx_clear;
  logic [DW-1:0] ctl_q, stat_q, rd_mux;

  spi_bus_front #(.ADDR_W(ADDR_W)) front_i (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .size(bus_size), .acc_start(acc_start), .acc_write(acc_write),
    .acc_err(acc_err), .acc_sel(acc_sel)
  );

  assign acc_ok      = acc_start & ~acc_err;
  assign wr_go       = acc_ok & acc_write;
  assign rd_go       = acc_ok & ~acc_write;
  assign ev_sw_stat  = wr_go && (acc_sel == REG_STAT);
  assign ev_tx_set   = wr_go && (acc_sel == REG_TX) && mode_active(ctl_q, MODE_TX);
  assign ev_rx_clear = rd_go && (acc_sel == REG_RX) && mode_active(ctl_q, MODE_RX);

  spi_status_unit status_i (
    .clk(clk), .rst_n(rst_n), .do_sw_write(ev_sw_stat), .do_tx_set(ev_tx_set),
    .do_rx_clear(ev_rx_clear), .wdata(bus_wdata), .stat_q(stat_q)
  );

  spi_reg_store store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .sel(acc_sel), .wdata(bus_wdata),
    .stat_in(stat_q), .ctl_q(ctl_q), .rd_mux(rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else if (acc_start) begin
      bus_err   <= acc_err;
      bus_rdata <= rd_go ? rd_mux : '0;
    end
  end

  assign status_o = stat_q;

  // R3: bad size reported on the following cycle
  a_r3_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && bus_size != SIZE_HALF) |=> bus_err);

  // R5: an error response never carries data
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R9: a held strobe leaves status and response untouched
  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !acc_start) |=> ($stable(status_o) && $stable(bus_rdata)));

  // R11: a write with both strobes never returns data
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && bus_wr) |=> (bus_rdata == '0));

endmodule

// File: tb/spi_regblk_tb_top.sv
module spi_regblk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b01;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, status_o;
  logic        bus_err;

  int checks = 0;
  int fails  = 0;

  // bench model of the seven registers
  logic [15:0] m_reg [7];

  always #2 clk = ~clk;

  spi_regblk #(.ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic bit expect_err(input logic [4:0] off, input logic [1:0] sz);
    return (sz != 2'b01) || (off[1:0] != 2'b00) || (off[4:2] > 3'd6);
  endfunction

  // Predict response, then advance the model
  task automatic model_step(input bit w, input logic [4:0] off, input logic [1:0] sz,
                            input logic [15:0] wd, output bit e_err, output logic [15:0] e_rd);
    int k;
    bit en_tx, en_rx;
    k = int'(off[4:2]);
    e_err = expect_err(off, sz);
    e_rd = '0;
    en_tx = m_reg[0][14] && (m_reg[0][1:0] == 2'd1);
    en_rx = m_reg[0][14] && (m_reg[0][1:0] == 2'd0);
    if (e_err) return;
    if (w) begin
      if (k == 2) m_reg[2] = m_reg[2] & ~(wd & 16'hFFD6);
      else m_reg[k] = wd;
      if (k == 3 && en_tx) m_reg[2] = (m_reg[2] | 16'h0020) & 16'hFFF7;
    end else begin
      e_rd = m_reg[k];
      if (k == 4 && en_rx) m_reg[2] = m_reg[2] & 16'hFFD7;
    end
  endtask

  task automatic op(input string tag, input bit w, input bit r, input logic [4:0] off,
                    input logic [1:0] sz, input logic [15:0] wd);
    bit e_err;
    logic [15:0] e_rd;
    model_step(w, off, sz, wd, e_err, e_rd);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = off; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    chk({tag, " err"}, {15'd0, bus_err}, {15'd0, e_err});
    chk({tag, " rdata"}, bus_rdata, e_rd);
    chk({tag, " status_o"}, status_o, m_reg[2]);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 7; k++) op(tag, 1'b0, 1'b1, 5'(k * 4), 2'b01, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) m_reg[k] = '0;
    m_reg[0] = 16'h0400; m_reg[1] = 16'hFF00; m_reg[2] = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 status_o", status_o, 16'h0001);
    chk("R1 rdata", bus_rdata, 16'h0000);
    chk("R1 err", {15'd0, bus_err}, 16'h0000);
    check_all("R1 reset readback");

    // R3 R4 R5: full read sweep of window and size codes
    for (int off = 0; off < 32; off++)
      for (int sz = 0; sz < 4; sz++)
        op("R3/R4 read sweep", 1'b0, 1'b1, 5'(off), 2'(sz), 16'h0);

    // R5: erroring writes leave every register intact
    for (int off = 0; off < 32; off++)
      for (int sz = 0; sz < 4; sz++)
        if (expect_err(5'(off), 2'(sz)))
          op("R5 bad write", 1'b1, 1'b0, 5'(off), 2'(sz), 16'hFFFF);
    check_all("R5 after bad writes");

    // R2: plain storage read-back
    op("R2 flg", 1'b1, 1'b0, 5'h04, 2'b01, 16'hA55A);
    op("R2 tx", 1'b1, 1'b0, 5'h0C, 2'b01, 16'h1234);
    op("R2 rx", 1'b1, 1'b0, 5'h10, 2'b01, 16'hBEEF);
    op("R2 baud", 1'b1, 1'b0, 5'h14, 2'b01, 16'h0042);
    op("R2 shadow", 1'b1, 1'b0, 5'h18, 2'b01, 16'h7E81);
    check_all("R2 readback");

    // R7 R8: enable x mode crossing
    for (int en = 0; en < 2; en++)
      for (int md = 0; md < 4; md++) begin
        op("R7 ctl set", 1'b1, 1'b0, 5'h00, 2'b01, 16'((en << 14) | md));
        op("R7 tx write", 1'b1, 1'b0, 5'h0C, 2'b01, 16'(16'h0100 + md));
        op("R8 rx read", 1'b0, 1'b1, 5'h10, 2'b01, 16'h0);
      end

    // R7 then R8: raise receive-ready then clear it
    op("R7 ctl tx mode", 1'b1, 1'b0, 5'h00, 2'b01, 16'h4001);
    op("R7 tx sets RXS", 1'b1, 1'b0, 5'h0C, 2'b01, 16'h00C3);
    chk("R7 RXS bit5 set", status_o & 16'h0028, 16'h0020);
    // R6: writing ones to status keeps hardware flags
    op("R6 w1c all", 1'b1, 1'b0, 5'h08, 2'b01, 16'hFFFF);
    chk("R6 flags kept", status_o, 16'h0021);
    op("R8 ctl disabled rx", 1'b1, 1'b0, 5'h00, 2'b01, 16'h0000);
    op("R8 rx no clear", 1'b0, 1'b1, 5'h10, 2'b01, 16'h0);
    chk("R8 disabled keeps RXS", status_o, 16'h0021);
    op("R8 ctl rx mode", 1'b1, 1'b0, 5'h00, 2'b01, 16'h4000);
    op("R8 rx clears", 1'b0, 1'b1, 5'h10, 2'b01, 16'h0);
    chk("R8 RXS cleared", status_o, 16'h0001);
    // R10: status read equals status_o
    op("R10 stat read", 1'b0, 1'b1, 5'h08, 2'b01, 16'h0);
    chk("R10 read matches port", bus_rdata, status_o);

    // R9: held strobe, offset changed mid-access
    op("R9 ctl tx mode", 1'b1, 1'b0, 5'h00, 2'b01, 16'h4001);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h14; bus_size = 2'b01; bus_wdata = 16'h0AAA;
    m_reg[5] = 16'h0AAA;
    @(negedge clk);
    chk("R9 resp valid", {15'd0, bus_err}, 16'h0000);
    @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = 16'h0BBB;
    repeat (3) @(negedge clk);
    chk("R9 no tx side effect", status_o, 16'h0001);
    bus_wr = 1'b0;
    op("R9 tx unchanged", 1'b0, 1'b1, 5'h0C, 2'b01, 16'h0);
    op("R9 baud once", 1'b0, 1'b1, 5'h14, 2'b01, 16'h0);
    // R9: response holds while idle
    repeat (3) @(negedge clk);
    chk("R9 response held", bus_rdata, 16'h0AAA);

    // R11: both strobes act as a write
    op("R11 both strobes", 1'b1, 1'b1, 5'h04, 2'b01, 16'h3C3C);
    check_all("R11 readback");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule